// File: doc/BRIEF.md
# I2C Condition Request Control Register

This block is the byte-wide control and status register of an I2C controller that decides when start, repeated-start and stop conditions are requested. Software writes request bits and mode bits through a simple write port and reads the full register back at any time. The block watches the synchronised SCL and SDA lines. It keeps its own view of whether the bus is occupied, and it tells a separate condition generator, through one-cycle strobes, when a request may be acted on.

A start request written while the bus is occupied is held. It is issued once the bus goes free. Each request clears itself when the matching condition appears on the lines, when arbitration is lost, or when the controller reset input is pulsed. The master and transmit mode bits change only while a write-unlock input is high.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads 0x00 and no issue strobe is high.
- R2: `rd_data` bit layout: [7] bus busy, [6] master mode, [5] transmit mode, [3] stop request, [2] restart request, [1] start request. Bits [4] and [0] always read 0, and writing 1 to them has no effect.
- R3: A write with `wr_en` high loads `wr_data[1]`, `wr_data[2]` and `wr_data[3]` into the start, restart and stop request bits. Writing 0 clears them.
- R4: `wr_data[6]` and `wr_data[5]` are loaded into the master and transmit mode bits only when `mode_unlock` is 1. Otherwise those bits keep their value.
- R5: The bus-busy bit is set when SDA falls while SCL stays high. It is cleared when SDA rises while SCL stays high. Software cannot write it. The line inputs pass through a two-flop synchroniser.
- R6: A pending start request raises `start_issue` for exactly one cycle, and only while the bus is free. It raises no second pulse until the request has been cleared and set again.
- R7: A start condition seen on the bus clears the start request. If a start was pending at that moment, the master mode bit is set.
- R8: `arb_lost` high clears the start, restart and stop requests.
- R9: `soft_rst` high clears all request bits and both mode bits. The bus-busy tracking is kept.
- R10: A restart request raises `restart_issue` once while the bus is busy. It clears on a start condition seen while the bus is busy.
- R11: A stop request raises `stop_issue` once while the bus is busy. It clears on a stop condition seen on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Controller reset pulse, clears requests and modes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| mode_unlock | input | 1 | Allows writes to the mode bits |
| arb_lost | input | 1 | Arbitration-lost event |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| rd_data | output | 8 | Register read value |
| start_issue | output | 1 | One-cycle start issue strobe |
| restart_issue | output | 1 | One-cycle restart issue strobe |
| stop_issue | output | 1 | One-cycle stop issue strobe |

## Verification
The hardest case to reach is a start request that is written while the bus is busy and must wait. The bench first drives a start condition on the raw lines so the bus reads busy. It then writes the request and confirms that no strobe appears. It releases the bus with a stop condition, counts exactly one strobe, and then drives a new start condition to show that the request clears and master mode is set. The busy flag is also swept over a long sequence of single-line toggles and compared against an arithmetic model of the line history.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int REG_W   = 8;
    localparam int BIT_BSY = 7;
    localparam int BIT_MST = 6;
    localparam int BIT_TRS = 5;
    localparam int BIT_SP  = 3;
    localparam int BIT_RS  = 2;
    localparam int BIT_ST  = 1;

    typedef struct packed {
        logic st;
        logic rs;
        logic sp;
        logic mst;
        logic trs;
        logic st_done;
        logic rs_done;
        logic sp_done;
        logic st_pulse;
        logic rs_pulse;
        logic sp_pulse;
    } req_state_t;

    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic busy;
    } mon_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign q[b] = chain_q[LAST];
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2c_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    mon_state_t s_d, s_q;

    always_comb begin
        start_det = s_q.scl_prev && scl_s && s_q.sda_prev && !sda_s;
        stop_det  = s_q.scl_prev && scl_s && !s_q.sda_prev && sda_s;
        s_d          = s_q;
        s_d.scl_prev = scl_s;
        s_d.sda_prev = sda_s;
        if (start_det)     s_d.busy = 1'b1;
        else if (stop_det) s_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, busy: 1'b0};
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    p_start_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy);
    p_stop_clears_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy);
endmodule

// File: rtl/i2c_req_regs.sv
module i2c_req_regs
    import i2c_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             mode_unlock,
    input  logic             arb_lost,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             busy,
    output logic             st,
    output logic             rs,
    output logic             sp,
    output logic             mst,
    output logic             trs,
    output logic             start_issue,
    output logic             restart_issue,
    output logic             stop_issue
);
    req_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.st_pulse = 1'b0;
        s_d.rs_pulse = 1'b0;
        s_d.sp_pulse = 1'b0;
        if (soft_rst) begin
            s_d = '0;
        end else begin
            if (wr_en) begin
                s_d.st = wr_data[BIT_ST];
                s_d.rs = wr_data[BIT_RS];
                s_d.sp = wr_data[BIT_SP];
                if (mode_unlock) begin
                    s_d.mst = wr_data[BIT_MST];
                    s_d.trs = wr_data[BIT_TRS];
                end
            end
            if (start_det && s_q.st) s_d.mst = 1'b1;
            if (start_det)           s_d.st  = 1'b0;
            if (start_det && busy)   s_d.rs  = 1'b0;
            if (stop_det)            s_d.sp  = 1'b0;
            if (arb_lost) begin
                s_d.st = 1'b0;
                s_d.rs = 1'b0;
                s_d.sp = 1'b0;
            end
            if (s_q.st && !busy && !s_q.st_done && !start_det && !arb_lost) begin
                s_d.st_pulse = 1'b1;
                s_d.st_done  = 1'b1;
            end
            if (s_q.rs && busy && !s_q.rs_done && !start_det && !arb_lost) begin
                s_d.rs_pulse = 1'b1;
                s_d.rs_done  = 1'b1;
            end
            if (s_q.sp && busy && !s_q.sp_done && !stop_det && !arb_lost) begin
                s_d.sp_pulse = 1'b1;
                s_d.sp_done  = 1'b1;
            end
            if (!s_d.st) s_d.st_done = 1'b0;
            if (!s_d.rs) s_d.rs_done = 1'b0;
            if (!s_d.sp) s_d.sp_done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st            = s_q.st;
    assign rs            = s_q.rs;
    assign sp            = s_q.sp;
    assign mst           = s_q.mst;
    assign trs           = s_q.trs;
    assign start_issue   = s_q.st_pulse;
    assign restart_issue = s_q.rs_pulse;
    assign stop_issue    = s_q.sp_pulse;

    p_start_free_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_issue |-> $past(!busy));
    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_issue |=> !start_issue);
    p_arb_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> (!st && !rs && !sp));
    p_soft_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!st && !rs && !sp && !mst && !trs));
    p_mode_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_unlock && !soft_rst && !(start_det && st)) |=> ($stable(mst) && $stable(trs)));
    p_start_det_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !soft_rst) |=> !st);
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             mode_unlock,
    input  logic             arb_lost,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic [REG_W-1:0] rd_data,
    output logic             start_issue,
    output logic             restart_issue,
    output logic             stop_issue
);
    logic [1:0] lines_s;
    logic start_det, stop_det, busy;
    logic st, rs, sp, mst, trs;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
    );

    i2c_bus_monitor u_mon (
        .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
        .start_det(start_det), .stop_det(stop_det), .busy(busy)
    );

    i2c_req_regs u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_data(wr_data), .mode_unlock(mode_unlock), .arb_lost(arb_lost),
        .start_det(start_det), .stop_det(stop_det), .busy(busy),
        .st(st), .rs(rs), .sp(sp), .mst(mst), .trs(trs),
        .start_issue(start_issue), .restart_issue(restart_issue),
        .stop_issue(stop_issue)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[BIT_BSY] = busy;
        rd_data[BIT_MST] = mst;
        rd_data[BIT_TRS] = trs;
        rd_data[BIT_SP]  = sp;
        rd_data[BIT_RS]  = rs;
        rd_data[BIT_ST]  = st;
    end

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_issue, restart_issue, stop_issue}) <= 2);
endmodule

// File: tb/tb_i2c_cond_ctrl.sv
module tb_i2c_cond_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, soft_rst = 0, wr_en = 0, mode_unlock = 0, arb_lost = 0;
    logic scl_in = 1, sda_in = 1;
    logic [7:0] wr_data = 0, rd_data;
    logic start_issue, restart_issue, stop_issue;
    int checks = 0, failures = 0, n_st = 0, n_rs = 0, n_sp = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cond_ctrl dut (.*);

    always @(negedge clk) begin
        if (start_issue)   n_st++;
        if (restart_issue) n_rs++;
        if (stop_issue)    n_sp++;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d, logic unl);
        @(negedge clk);
        wr_en = 1; wr_data = d; mode_unlock = unl;
        @(negedge clk);
        wr_en = 0; mode_unlock = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic lines(logic c, logic d);
        @(negedge clk);
        scl_in = c; sda_in = d;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_in(ref logic sig);
        @(negedge clk);
        sig = 1;
        @(negedge clk);
        sig = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int b0, b1;
        logic exp_busy;
        logic c, d, nc, nd;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset", rd_data, 8'h00);
        chk("R1 strobes", {start_issue, restart_issue, stop_issue}, 0);

        // R5 sweep of single-line toggles, model busy arithmetically
        exp_busy = 0; c = 1; d = 1;
        for (int i = 0; i < 48; i++) begin
            nc = c; nd = d;
            if ((i % 3) == 0) nc = ~c; else nd = ~d;
            if (c && nc && d && !nd) exp_busy = 1;
            if (c && nc && !d && nd) exp_busy = 0;
            lines(nc, nd);
            c = nc; d = nd;
            chk("R5 busy sweep", rd_data[7], exp_busy);
        end
        chk("R7 no mst without request", rd_data[6], 0);
        lines(0, d); lines(0, 0); lines(1, 0); lines(1, 1);
        chk("R5 bus released", rd_data, 8'h00);

        // R2 R3 reserved bits, request write and clear
        b0 = n_st;
        wr(8'hFF, 0);
        chk("R2 R3 write all ones", rd_data, 8'h0E);
        chk("R6 free bus single strobe", n_st - b0, 1);
        wr(8'h00, 0);
        chk("R3 clear by write", rd_data, 8'h00);

        // R4 mode lock
        wr(8'h60, 1);
        chk("R4 unlocked write", rd_data, 8'h60);
        wr(8'h00, 0);
        chk("R4 locked write ignored", rd_data, 8'h60);
        wr(8'h20, 1);
        chk("R4 unlocked partial", rd_data, 8'h20);
        wr(8'h00, 1);

        // R6 R7 start held while busy
        lines(1, 0);
        chk("R5 busy after start", rd_data, 8'h80);
        b0 = n_st;
        wr(8'h02, 0);
        repeat (10) @(negedge clk);
        chk("R6 no strobe while busy", n_st - b0, 0);
        lines(1, 1);
        chk("R6 strobe once bus free", n_st - b0, 1);
        repeat (10) @(negedge clk);
        chk("R6 no repeat strobe", n_st - b0, 1);
        lines(1, 0);
        chk("R7 start clears request sets master", rd_data, 8'hC0);

        // R10 restart
        b1 = n_rs;
        wr(8'h04, 0);
        chk("R10 restart strobe", n_rs - b1, 1);
        chk("R10 restart pending", rd_data, 8'hC4);
        lines(0, 0); lines(0, 1); lines(1, 1); lines(1, 0);
        chk("R10 repeated start clears", rd_data, 8'hC0);
        chk("R10 single restart strobe", n_rs - b1, 1);

        // R11 stop
        b1 = n_sp;
        wr(8'h08, 0);
        chk("R11 stop strobe", n_sp - b1, 1);
        chk("R11 stop pending", rd_data, 8'hC8);
        lines(1, 1);
        chk("R11 stop clears", rd_data, 8'h40);

        // R8 arbitration loss
        lines(1, 0);
        b0 = n_st;
        wr(8'h0E, 0);
        chk("R8 requests set", rd_data, 8'hCE);
        chk("R6 held while busy", n_st - b0, 0);
        pulse_in(arb_lost);
        chk("R8 arb clears requests", rd_data, 8'hC0);

        // R9 soft reset keeps busy
        wr(8'h6C, 1);
        chk("R9 before soft reset", rd_data, 8'hEC);
        pulse_in(soft_rst);
        chk("R9 soft reset", rd_data, 8'h80);
        lines(1, 1);
        chk("R9 bus free after", rd_data, 8'h00);

        // R6 re-arm
        b0 = n_st;
        wr(8'h02, 0);
        wr(8'h02, 0);
        chk("R6 rewrite no new strobe", n_st - b0, 1);
        wr(8'h00, 0);
        wr(8'h02, 0);
        chk("R6 rearm new strobe", n_st - b0, 2);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule